// File: doc/BRIEF.md
# Per-Core Exclusive Access Monitor

This block watches a core's stream of memory requests and decides whether each store-exclusive may reach memory. A load-exclusive arms the monitor and records the naturally aligned region (granule) holding the loaded address. A later store-exclusive succeeds only while the monitor is armed. Every store-exclusive, whether it passes or fails, disarms the monitor. Lock code therefore retries a failed store by issuing a new load-exclusive. A clear-exclusive request disarms the monitor without storing anything.

Requests arrive on a valid/ready port. Ready is always high, so the block never applies back-pressure, and a request is taken in every cycle where valid is high. The block returns two signals in the same cycle as the request: a write enable, which the surrounding memory path uses to gate the store, and a status bit (0 means success, 1 means failure). A parameter chooses how strict the monitor is. In the default variant, a store succeeds whenever the monitor is armed, whatever the store address. In the tagged variant, the store address must also fall in the recorded granule. The granule size is a parameter given as log2 of a byte count.

Top module: `exclusive_monitor`

## Requirements
- R1: After reset the monitor is open, so a store-exclusive (req_op = 2) gives st_we = 0 and st_status = 1.
- R2: A valid load-exclusive (req_op = 1) arms the monitor. The next store-exclusive then gives st_we = 1 and st_status = 0 in the cycle it is presented.
- R3: A load-exclusive issued while the monitor is already armed keeps it armed, and the recorded granule moves to the new address.
- R4: Every store-exclusive leaves the monitor open, so a second store-exclusive with no load-exclusive between the two fails.
- R5: A store-exclusive presented while the monitor is open never asserts st_we, so memory keeps its previous value, and it returns st_status = 1.
- R6: A clear-exclusive (req_op = 3) opens the monitor.
- R7: st_we and st_status are both 0 in every cycle that does not carry a valid store-exclusive. This includes ordinary accesses (req_op = 0) and cycles with req_valid low.
- R8: Ordinary accesses (req_op = 0) do not change the monitor state.
- R9: With ADDR_CHECK = 1, a store-exclusive succeeds only if its address has the same bits above GRAN_LOG2 as the last load-exclusive. A store to another granule fails and still opens the monitor. With ADDR_CHECK = 0, the store address is not checked.
- R10: req_ready is always 1. A request with req_valid = 0 has no effect on the monitor, whatever its op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1; request taken when valid |
| req_op | input | 2 | 0 ordinary, 1 load-excl, 2 store-excl, 3 clear |
| req_addr | input | ADDR_W | Byte address of the request |
| st_we | output | 1 | Store-exclusive may write memory (same cycle) |
| st_status | output | 1 | Store-exclusive result: 0 success, 1 fail |

## Verification
The hardest case to reach from the ports is a store-exclusive whose address lies in a different granule from the one recorded, made after a second load-exclusive has already moved the recorded granule. The two variants give different results in that case. The bench drives one request stream into both variants side by side. It runs directed spinlock-style sequences, including an interleaving where two lock attempts share one monitor and offsets sit at the granule edges (63 and 64). It then runs a random stream drawn from a few addresses close to one granule boundary, so that same-granule and cross-granule stores both occur often.

// File: rtl/exmon_pkg.sv
package exmon_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_LDX   = 2'd1,
    OP_STX   = 2'd2,
    OP_CLR   = 2'd3
  } exmon_op_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } exmon_state_e;

  typedef struct packed {
    logic ld;
    logic st;
    logic clr;
  } exmon_cmd_t;
endpackage

// File: rtl/exmon_decode.sv
module exmon_decode
  import exmon_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] op,
  output exmon_cmd_t cmd
);
  exmon_op_e op_e;

  always_comb begin
    op_e    = exmon_op_e'(op);
    cmd     = '0;
    if (valid) begin
      unique case (op_e)
        OP_LDX:  cmd.ld  = 1'b1;
        OP_STX:  cmd.st  = 1'b1;
        OP_CLR:  cmd.clr = 1'b1;
        default: cmd     = '0;
      endcase
    end
  end
endmodule

// File: rtl/exmon_tag.sv
module exmon_tag #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - GRAN_LOG2;

  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] tag_in;

  assign tag_in = addr[ADDR_W-1:GRAN_LOG2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else if (capture) tag_q <= tag_in;
  end

  assign hit = (tag_in == tag_q);

  generate
    if (GRAN_LOG2 > 0) begin : g_low
      logic [GRAN_LOG2-1:0] offs_unused;
      assign offs_unused = addr[GRAN_LOG2-1:0];
    end
  endgenerate
endmodule

// File: rtl/exmon_fsm.sv
module exmon_fsm
  import exmon_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  exmon_cmd_t   cmd,
  output exmon_state_e state_q
);
  exmon_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (cmd.st || cmd.clr) state_d = MON_OPEN;
    else if (cmd.ld)       state_d = MON_EXCL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MON_OPEN;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/exclusive_monitor.sv
module exclusive_monitor
  import exmon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRAN_LOG2  = 6,
  parameter int ADDR_CHECK = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              st_we,
  output logic              st_status
);
  exmon_cmd_t   cmd;
  exmon_state_e mon_state;
  logic         tag_hit;
  logic         granted;
  logic         excl_q;

  assign req_ready = 1'b1;

  exmon_decode u_dec (
    .valid (req_valid),
    .op    (req_op),
    .cmd   (cmd)
  );

  exmon_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .state_q (mon_state)
  );

  exmon_tag #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_tag (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (cmd.ld),
    .addr    (req_addr),
    .hit     (tag_hit)
  );

  assign excl_q = (mon_state == MON_EXCL);

  generate
    if (ADDR_CHECK != 0) begin : g_tagged
      assign granted = excl_q & tag_hit;
    end else begin : g_plain
      logic hit_unused;
      assign hit_unused = tag_hit;
      assign granted = excl_q;
    end
  endgenerate

  assign st_we     = cmd.st &  granted;
  assign st_status = cmd.st & ~granted;
endmodule

// File: rtl/exmon_chk.sv
module exmon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       st_we,
  input logic       st_status,
  input logic       excl_q
);
  logic is_st, is_ld, is_clr;
  assign is_st  = req_valid && req_op == 2'd2;
  assign is_ld  = req_valid && req_op == 2'd1;
  assign is_clr = req_valid && req_op == 2'd3;

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !is_st |-> (!st_we && !st_status));
  a_r4_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    is_st |-> (st_we != st_status));
  a_r4_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    is_st |=> !excl_q);
  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    is_ld |=> excl_q);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> !excl_q);
  a_r5_open_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (is_st && !excl_q) |-> (!st_we && st_status));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_st && !is_ld && !is_clr) |=> $stable(excl_q));
  a_r10_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
endmodule

bind exclusive_monitor exmon_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_op    (req_op),
  .st_we     (st_we),
  .st_status (st_status),
  .excl_q    (excl_q)
);

// File: tb/exclusive_monitor_tb.sv
module exclusive_monitor_tb;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int G  = 6;

  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [1:0] req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic rdy_u, we_u, st_u, rdy_t, we_t, st_t;

  int checks = 0, fails = 0;
  int m_excl = 0;
  longint m_tag = 0;
  int unsigned wdata = 1;
  int unsigned mem_u[int unsigned];
  int unsigned mem_t[int unsigned];
  int unsigned exp_u[int unsigned];
  int unsigned exp_t[int unsigned];

  always #(CLK_P/2) clk = ~clk;

  exclusive_monitor #(.ADDR_W(AW), .GRAN_LOG2(G), .ADDR_CHECK(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_u),
    .req_op(req_op), .req_addr(req_addr), .st_we(we_u), .st_status(st_u));

  exclusive_monitor #(.ADDR_W(AW), .GRAN_LOG2(G), .ADDR_CHECK(1)) u_dut_tag (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_t),
    .req_op(req_op), .req_addr(req_addr), .st_we(we_t), .st_status(st_t));

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // one request, compared against the behavioural model, then model update
  task automatic op(string rq, bit v, int o, int unsigned a);
    bit st, pu, pt;
    @(negedge clk);
    req_valid = v; req_op = 2'(o); req_addr = a;
    #(CLK_P/4);
    st = v && o == 2;
    pu = st && m_excl != 0;
    pt = pu && ((longint'(a) >> G) == m_tag);
    chk(rq, "ready", int'(rdy_u & rdy_t), 1);
    chk(rq, "we plain", int'(we_u), int'(pu));
    chk(rq, "status plain", int'(st_u), int'(st && !pu));
    chk(rq, "we tagged", int'(we_t), int'(pt));
    chk(rq, "status tagged", int'(st_t), int'(st && !pt));
    if (we_u) mem_u[a] = wdata;
    if (we_t) mem_t[a] = wdata;
    if (pu) exp_u[a] = wdata;
    if (pt) exp_t[a] = wdata;
    wdata++;
    if (v) begin
      if (o == 1) begin m_excl = 1; m_tag = longint'(a) >> G; end
      else if (o == 2 || o == 3) m_excl = 0;
    end
  endtask

  localparam int unsigned LK1 = 32'h1000;
  localparam int unsigned LK2 = 32'h2000;

  initial begin
    #(CLK_P*150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P*3) rst_n = 1;
    op("R7", 0, 0, 0);               // idle after reset
    op("R1", 1, 2, LK1);             // store right after reset fails
    op("R2", 1, 1, LK1);
    op("R2", 1, 2, LK1);             // succeeds
    op("R4", 1, 1, LK1);
    op("R4", 1, 2, LK1);
    op("R4", 1, 2, LK1);             // second store fails
    op("R5", 1, 2, LK2);             // open store, no write
    // two lock attempts interleaved on one monitor
    op("R3", 1, 1, LK1);
    op("R3", 1, 1, LK2);             // stays armed, granule moves
    op("R9", 1, 2, LK1);             // plain passes, tagged fails
    op("R4", 1, 2, LK2);             // already open: both fail
    op("R6", 1, 1, LK1);
    op("R6", 1, 3, 0);
    op("R6", 1, 2, LK1);
    op("R8", 1, 1, LK1);
    op("R8", 1, 0, LK2);
    op("R8", 1, 0, LK1);
    op("R8", 1, 2, LK1);             // still armed
    op("R10", 1, 1, LK1);
    op("R10", 0, 3, 0);              // invalid clear ignored
    op("R7", 0, 2, LK1);             // invalid store silent
    op("R10", 1, 2, LK1);
    op("R9", 1, 1, LK1);
    op("R9", 1, 2, LK1 + 63);        // same granule
    op("R9", 1, 1, LK1);
    op("R9", 1, 2, LK1 + 64);        // next granule
    op("R9", 1, 2, LK1);             // opened by failed store
    op("R7", 1, 0, LK1);
    for (int i = 0; i < 400; i++) begin
      int unsigned a;
      a = LK1 + 32'($urandom_range(0, 3)) * 32 + 32'($urandom_range(0, 1)) * 16;
      op("R9", ($urandom_range(0, 7) != 0), int'($urandom_range(0, 3)), a);
    end
    // memory contents produced through the gate must match the model
    chk("R5", "mem size plain", mem_u.num(), exp_u.num());
    chk("R5", "mem size tagged", mem_t.num(), exp_t.num());
    foreach (exp_u[k]) chk("R5", "mem plain", int'(mem_u.exists(k) ? mem_u[k] : 0), int'(exp_u[k]));
    foreach (exp_t[k]) chk("R5", "mem tagged", int'(mem_t.exists(k) ? mem_t[k] : 0), int'(exp_t[k]));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule